// File: doc/BRIEF.md
# Watchdog Timer with Disable Lockout

This block is a supervision timer for a processor subsystem. An 8-bit counter advances once per clock while the block is enabled and running. If software does not write the service register before the counter passes its top value, the block raises a one-cycle reset request, which the chip's reset logic turns into a system reset. Any write to the service register restarts the count from zero.

Software can turn the timer off with a disable bit, but only while a guard bit still holds its reset value of 1. The guard bit can only be cleared. Writing 1 to it clears it, and after that the disable bit is stored and read back but no longer stops the counter. Only a reset can bring the guard back to 1. Boot code that wants the timer permanently armed clears the guard early in its sequence.

The register port has a write strobe with address and data, and a read address with registered read data. Register map (address: content): 0 control, bit 0 = disable; 1 guard, bit 0 = guard; 2 service, write-only; 3 counter value, read-only.

Top module: `wdog_lockout`

## Requirements
- R1: Reset sets the counter to 0, the disable bit to 0, the guard bit to 1, and holds the reset request low.
- R2: While running, the counter increases by exactly one on each clock. Running means `en` is 1 and the disable bit and the guard bit are not both 1.
- R3: On the clock where a running counter wraps from 255 to 0, `rst_req` goes high for exactly one cycle, and the counter already reads 0 in that cycle.
- R4: A write to address 2, with any data, clears the counter on that clock. If the counter is at 255 in that cycle, the write wins: the counter goes to 0 and no reset request is produced.
- R5: While `en` is 0, the counter holds its value and no reset request is produced.
- R6: While the guard bit is 1 and the disable bit (address 0, bit 0) is 1, the counter holds its value and no reset request is produced.
- R7: The guard bit (address 1, bit 0) is clear-only. Writing 1 to bit 0 clears it, writing 0 leaves it unchanged, and no write returns it to 1.
- R8: Once the guard bit is 0, the disable bit has no effect on counting or on overflow, although its stored value still reads back.
- R9: `rd_data` shows, one clock after `rd_addr` is presented, the addressed register: address 0 gives the disable bit in bit 0, address 1 the guard bit in bit 0, address 3 the counter value, and address 2 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Master enable for counting |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Registered read data |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A counter that skips or stalls moves the reset request away from the 256th running clock. The bench sees this at the first overflow it times, and at the latest within one counter period. A guard bit that comes back to 1, or that never clears, shows up on the next read of address 1. It also shows up as a missing pulse while the disable bit is set. A service write that loses to the overflow produces an extra `rst_req` pulse in that same cycle, and a pulse wider than one cycle is counted twice at once.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_GUARD = 2'd1,
    REG_KICK  = 2'd2,
    REG_COUNT = 2'd3
  } wdog_reg_e;

  typedef struct packed {
    logic dis;
    logic guard;
  } wdog_cfg_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output wdog_cfg_t         cfg,
  output logic              kick
);
  logic unused_wr_hi;
  assign unused_wr_hi = ^wr_data[DATA_W-1:1];

  assign kick = wr_en && (wr_addr == REG_KICK);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.dis   <= 1'b0;
      cfg.guard <= 1'b1;
    end else if (wr_en) begin
      case (wr_addr)
        REG_CTRL:  cfg.dis <= wr_data[0];
        REG_GUARD: if (wr_data[0]) cfg.guard <= 1'b0;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             kick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_pulse
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      wrap_pulse <= 1'b0;
    end else begin
      wrap_pulse <= 1'b0;
      if (kick) begin
        cnt <= '0;
      end else if (run) begin
        if (cnt == TOP) begin
          cnt        <= '0;
          wrap_pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdog_lockout.sv
module wdog_lockout
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rst_req
);
  localparam int unsigned PAD_W = DATA_W - 1;

  wdog_cfg_t        cfg;
  logic             kick;
  logic             dis_q;
  logic             guard_q;
  logic             run;
  logic [CNT_W-1:0] cnt;

  wdog_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg     (cfg),
    .kick    (kick)
  );

  assign dis_q   = cfg.dis;
  assign guard_q = cfg.guard;
  assign run     = en && !(dis_q && guard_q);

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .kick       (kick),
    .cnt        (cnt),
    .wrap_pulse (rst_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        REG_CTRL:  rd_data <= {{PAD_W{1'b0}}, dis_q};
        REG_GUARD: rd_data <= {{PAD_W{1'b0}}, guard_q};
        REG_COUNT: rd_data <= DATA_W'(cnt);
        default:   rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_lockout_chk.sv
module wdog_lockout_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             kick,
  input logic             dis_q,
  input logic             guard_q,
  input logic [CNT_W-1:0] cnt,
  input logic             rst_req
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  // R3
  pulse_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (cnt == '0));
  // R4
  kick_clear_chk: assert property (@(posedge clk) disable iff (rst)
    kick |=> (cnt == '0 && !rst_req));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !kick) |=> ($stable(cnt) && !rst_req));
  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dis_q && guard_q && !kick) |=> ($stable(cnt) && !rst_req));
  // R7
  guard_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(guard_q));
  // R8
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !(dis_q && guard_q) && !kick && cnt != TOP)
      |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

bind wdog_lockout wdog_lockout_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .kick    (kick),
  .dis_q   (dis_q),
  .guard_q (guard_q),
  .cnt     (cnt),
  .rst_req (rst_req)
);

// File: tb/sim_wdog_lockout.sv
`timescale 1ns/1ps
module sim_wdog_lockout;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NVEC   = 49;

  // op: 0 write, 1 set en, 2 run cycles, 3 read+compare, 4 pulse count compare
  typedef struct packed {
    logic [2:0] op;
    logic [1:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{3'd3, 2'd3, 8'd0,   8'd0,   4'd1},  // R1 count 0
    '{3'd3, 2'd1, 8'd0,   8'd1,   4'd1},  // R1 guard 1
    '{3'd3, 2'd0, 8'd0,   8'd0,   4'd1},  // R1 disable 0
    '{3'd4, 2'd0, 8'd0,   8'd0,   4'd1},
    '{3'd1, 2'd0, 8'd1,   8'd0,   4'd2},
    '{3'd2, 2'd0, 8'd255, 8'd0,   4'd2},
    '{3'd1, 2'd0, 8'd0,   8'd0,   4'd2},
    '{3'd3, 2'd3, 8'd0,   8'd255, 4'd2},  // R2 counted to top
    '{3'd1, 2'd0, 8'd1,   8'd0,   4'd3},
    '{3'd2, 2'd0, 8'd1,   8'd0,   4'd3},
    '{3'd4, 2'd0, 8'd0,   8'd1,   4'd3},  // R3 one pulse
    '{3'd1, 2'd0, 8'd0,   8'd0,   4'd3},
    '{3'd3, 2'd3, 8'd0,   8'd0,   4'd3},  // R3 wrapped to 0
    '{3'd1, 2'd0, 8'd1,   8'd0,   4'd4},
    '{3'd2, 2'd0, 8'd200, 8'd0,   4'd4},
    '{3'd0, 2'd2, 8'd0,   8'd0,   4'd4},
    '{3'd2, 2'd0, 8'd200, 8'd0,   4'd4},
    '{3'd0, 2'd2, 8'd0,   8'd0,   4'd4},
    '{3'd2, 2'd0, 8'd255, 8'd0,   4'd4},
    '{3'd0, 2'd2, 8'd0,   8'd0,   4'd4},  // R4 service at top
    '{3'd4, 2'd0, 8'd0,   8'd0,   4'd4},
    '{3'd1, 2'd0, 8'd0,   8'd0,   4'd4},
    '{3'd3, 2'd3, 8'd0,   8'd0,   4'd4},
    '{3'd1, 2'd0, 8'd1,   8'd0,   4'd6},
    '{3'd0, 2'd0, 8'd1,   8'd0,   4'd6},  // R6 disable with guard set
    '{3'd2, 2'd0, 8'd255, 8'd0,   4'd6},
    '{3'd2, 2'd0, 8'd255, 8'd0,   4'd6},
    '{3'd4, 2'd0, 8'd0,   8'd0,   4'd6},
    '{3'd3, 2'd3, 8'd0,   8'd1,   4'd6},
    '{3'd3, 2'd0, 8'd0,   8'd1,   4'd9},
    '{3'd0, 2'd0, 8'd0,   8'd0,   4'd6},
    '{3'd2, 2'd0, 8'd10,  8'd0,   4'd2},
    '{3'd0, 2'd1, 8'd0,   8'd0,   4'd7},  // R7 write 0 ignored
    '{3'd3, 2'd1, 8'd0,   8'd1,   4'd7},
    '{3'd0, 2'd1, 8'd1,   8'd0,   4'd7},
    '{3'd3, 2'd1, 8'd0,   8'd0,   4'd7},
    '{3'd0, 2'd0, 8'd1,   8'd0,   4'd8},  // R8 disable ignored
    '{3'd2, 2'd0, 8'd239, 8'd0,   4'd8},
    '{3'd4, 2'd0, 8'd0,   8'd0,   4'd8},
    '{3'd2, 2'd0, 8'd1,   8'd0,   4'd8},
    '{3'd4, 2'd0, 8'd0,   8'd1,   4'd8},
    '{3'd1, 2'd0, 8'd0,   8'd0,   4'd8},
    '{3'd3, 2'd3, 8'd0,   8'd0,   4'd8},
    '{3'd3, 2'd0, 8'd0,   8'd1,   4'd8},
    '{3'd3, 2'd1, 8'd0,   8'd0,   4'd7},
    '{3'd2, 2'd0, 8'd50,  8'd0,   4'd5},  // R5 en low
    '{3'd4, 2'd0, 8'd0,   8'd0,   4'd5},
    '{3'd3, 2'd3, 8'd0,   8'd0,   4'd5},
    '{3'd3, 2'd2, 8'd0,   8'd0,   4'd9}   // R9 service reads 0
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en = 1'b0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [1:0]        rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic              rst_req;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;

  always #2 clk = ~clk;

  wdog_lockout u0 (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .rst_req (rst_req)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (rst_req) pulses++;
  endtask

  task automatic chk(input int req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL R%0d actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, input int exp, input int req);
    rd_addr = a;
    tick();
    chk(req, int'(rd_data), exp);
  endtask

  task automatic do_run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_pchk(input int exp, input int req);
    chk(req, pulses, exp);
    pulses = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    chk(1, int'(rst_req), 0);  // R1 request low in reset
    rst = 1'b0;
    tick();
    chk(1, int'(rst_req), 0);  // R1
    pulses = 0;

    for (int v = 0; v < NVEC; v++) begin
      case (VEC[v].op)
        3'd0: do_wr(VEC[v].addr, VEC[v].data);
        3'd1: en = VEC[v].data[0];
        3'd2: do_run(int'(VEC[v].data));
        3'd3: do_rd(VEC[v].addr, int'(VEC[v].exp), int'(VEC[v].req));
        default: do_pchk(int'(VEC[v].exp), int'(VEC[v].req));
      endcase
    end

    // R1: reset in mid-run restores guard, disable and count
    en = 1'b1;
    do_run(100);
    en = 1'b0;
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
    chk(1, int'(rst_req), 0);
    do_rd(2'd3, 0, 1);
    do_rd(2'd1, 1, 1);
    do_rd(2'd0, 0, 1);
    pulses = 0;

    // R6: disable works again after reset
    en = 1'b1;
    do_wr(2'd0, 8'd1);
    do_run(255);
    do_run(255);
    do_pchk(0, 6);
    do_rd(2'd3, 1, 6);

    // R3: pulse lasts one cycle and the count restarts at 0
    do_wr(2'd0, 8'd0);
    do_run(254);
    do_pchk(0, 3);
    do_run(1);
    chk(3, int'(rst_req), 1);
    do_run(1);
    chk(3, int'(rst_req), 0);
    do_pchk(1, 3);
    en = 1'b0;
    do_rd(2'd3, 1, 3);

    finish_run();
  end
endmodule